// File: doc/BRIEF.md
# Decimal-capable 8-bit ALU with compare

This unit computes the arithmetic part of an 8-bit accumulator machine. It offers three operations: add with carry, subtract with borrow, and compare. A decimal-mode input switches add and subtract to packed-BCD arithmetic (two digits per byte). Compare is always binary.

The unit captures an operation select, a register operand (accumulator or index), a memory operand, a carry-in and the decimal flag on one clock edge. On the next edge it presents registered outputs:

- the result byte and a write-enable for the destination register;
- carry, zero, overflow and negative values, each with its own update enable.

A surrounding core uses the enables to decide which status bits and which register it writes back.

Top module: `bcd_alu8`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: `op_sel` encodes 00 = add, 01 = subtract, 10 = compare, 11 = idle. Each output reflects the inputs sampled at the previous rising clock edge.
- R3: Binary add (dec_mode = 0):
  - {flag_c, res} = opa + opb + carry_in as a 9-bit sum.
  - flag_v = 1 when the signed sum lies outside -128..127.
- R4: Binary subtract:
  - res = (opa - opb - (1 - carry_in)) mod 256.
  - flag_c = 1 when no borrow occurred.
  - flag_v = 1 when the signed difference lies outside -128..127.
- R5: Decimal add with valid BCD operands:
  - res is the BCD encoding of (A + M + carry_in) mod 100, where A and M are the decimal values of the operands.
  - flag_c = 1 when that sum exceeds 99.
  - flag_v is bit 7 of ((opa ^ res) & (opb ^ res)).
- R6: Decimal subtract with valid BCD operands:
  - res is the BCD encoding of (A - M - (1 - carry_in)) mod 100.
  - flag_c = 1 when the difference is not negative.
  - flag_v is the binary signed overflow of the same subtraction.
- R7: Compare:
  - flag_c = 1 when opa >= opb as unsigned values.
  - flag_z = 1 when they are equal.
  - flag_n is bit 7 of (opa - opb) mod 256; `res` carries that wrapped difference.
  - carry_in and dec_mode have no effect.
- R8: Compare:
  - res_we = 0, upd_v = 0 and flag_v = 0.
  - upd_c, upd_z and upd_n are 1.
- R9: Add and subtract drive res_we and all four update enables to 1.
- R10: Whenever a flag is updated, flag_z = 1 exactly when res is 0, and flag_n equals res[7].
- R11: Idle drives res, res_we, every flag and every update enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 compare, 11 idle |
| opa | input | 8 | Register operand (accumulator or index) |
| opb | input | 8 | Memory operand |
| carry_in | input | 1 | Incoming carry; 1 means no borrow for subtract |
| dec_mode | input | 1 | Selects BCD correction for add and subtract |
| res | output | 8 | Result byte (wrapped difference for compare) |
| res_we | output | 1 | Destination register write-enable |
| flag_c | output | 1 | Carry value |
| flag_z | output | 1 | Zero value |
| flag_v | output | 1 | Overflow value |
| flag_n | output | 1 | Negative value |
| upd_c | output | 1 | Carry update enable |
| upd_z | output | 1 | Zero update enable |
| upd_v | output | 1 | Overflow update enable |
| upd_n | output | 1 | Negative update enable |

## Verification
The unit holds no state beyond one output register, so any fault appears at the ports one clock after the offending operands are applied. That makes every vector observable on its own.

A wrong BCD digit correction appears as a result nibble above nine, or as a carry that disagrees with the decimal sum. A swapped enable shows as a compare that writes the register or touches overflow.

The bench sweeps operand pairs densely in both radices against a reference built on integer and decimal-digit arithmetic. It also drives the decimal and carry inputs during compares to show that they are ignored.

// File: rtl/bcd_alu8.sv
module bcd_alu8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] op_sel,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  input  logic       carry_in,
  input  logic       dec_mode,
  output logic [7:0] res,
  output logic       res_we,
  output logic       flag_c,
  output logic       flag_z,
  output logic       flag_v,
  output logic       flag_n,
  output logic       upd_c,
  output logic       upd_z,
  output logic       upd_v,
  output logic       upd_n
);
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_SUB = 2'b01;
  localparam logic [1:0] OP_CMP = 2'b10;

  // add path: binary sum, then low-digit and high-digit decimal fix-ups
  logic [4:0] add_lo_sum;
  logic [9:0] add_raw, add_mid, add_fin;
  logic       add_fix_lo, add_fix_hi, add_c, add_v;

  assign add_lo_sum = {1'b0, opa[3:0]} + {1'b0, opb[3:0]} + {4'b0, carry_in};
  assign add_fix_lo = dec_mode && (add_lo_sum > 5'd9);
  assign add_raw    = {2'b0, opa} + {2'b0, opb} + {9'b0, carry_in};
  assign add_mid    = add_raw + (add_fix_lo ? 10'h006 : 10'h000);
  assign add_fix_hi = dec_mode && (add_mid[9:4] > 6'd9);
  assign add_fin    = add_mid + (add_fix_hi ? 10'h060 : 10'h000);
  assign add_c      = |add_fin[9:8];
  assign add_v      = (opa[7] ^ add_fin[7]) & (opb[7] ^ add_fin[7]);

  // subtract path: binary difference, decimal digits pulled down on borrow
  logic [5:0] sub_lo_dif;
  logic [8:0] sub_raw;
  logic [7:0] sub_fin;
  logic       sub_lo_b, sub_hi_b, sub_v;

  assign sub_lo_dif = {2'b0, opa[3:0]} - {2'b0, opb[3:0]} - {5'b0, ~carry_in};
  assign sub_lo_b   = sub_lo_dif[5];
  assign sub_raw    = {1'b0, opa} - {1'b0, opb} - {8'b0, ~carry_in};
  assign sub_hi_b   = sub_raw[8];
  assign sub_fin    = sub_raw[7:0]
                    - ((dec_mode && sub_lo_b) ? 8'h06 : 8'h00)
                    - ((dec_mode && sub_hi_b) ? 8'h60 : 8'h00);
  assign sub_v      = (opa[7] ^ opb[7]) & (opa[7] ^ sub_raw[7]);

  // compare path: always binary
  logic [8:0] cmp_raw;
  assign cmp_raw = {1'b0, opa} - {1'b0, opb};

  logic [7:0] nx_res;
  logic       nx_act, nx_we, nx_c, nx_v, nx_uv;

  always_comb begin
    nx_res = 8'h00;
    nx_act = 1'b0;
    nx_we  = 1'b0;
    nx_c   = 1'b0;
    nx_v   = 1'b0;
    nx_uv  = 1'b0;
    case (op_sel)
      OP_ADD: begin
        nx_res = add_fin[7:0];
        nx_act = 1'b1;
        nx_we  = 1'b1;
        nx_c   = add_c;
        nx_v   = add_v;
        nx_uv  = 1'b1;
      end
      OP_SUB: begin
        nx_res = sub_fin;
        nx_act = 1'b1;
        nx_we  = 1'b1;
        nx_c   = ~sub_hi_b;
        nx_v   = sub_v;
        nx_uv  = 1'b1;
      end
      OP_CMP: begin
        nx_res = cmp_raw[7:0];
        nx_act = 1'b1;
        nx_c   = ~cmp_raw[8];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res    <= 8'h00;
      res_we <= 1'b0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_n <= 1'b0;
      upd_c  <= 1'b0;
      upd_z  <= 1'b0;
      upd_v  <= 1'b0;
      upd_n  <= 1'b0;
    end else begin
      res    <= nx_res;
      res_we <= nx_we;
      flag_c <= nx_c;
      flag_z <= nx_act && (nx_res == 8'h00);
      flag_v <= nx_v;
      flag_n <= nx_act && nx_res[7];
      upd_c  <= nx_act;
      upd_z  <= nx_act;
      upd_v  <= nx_uv;
      upd_n  <= nx_act;
    end
  end
endmodule

// File: rtl/bcd_alu8_sva.sv
module bcd_alu8_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] op_sel,
  input logic [7:0] opa,
  input logic [7:0] opb,
  input logic       carry_in,
  input logic       dec_mode,
  input logic [7:0] res,
  input logic       res_we,
  input logic       flag_c,
  input logic       flag_z,
  input logic       flag_v,
  input logic       flag_n,
  input logic       upd_c,
  input logic       upd_z,
  input logic       upd_v,
  input logic       upd_n
);
  a_r3_add_binary: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b00 && !dec_mode) |=>
      ({flag_c, res} == ($past({1'b0, opa}) + $past({1'b0, opb}) + {8'b0, $past(carry_in)})));

  a_r7_cmp_order: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b10) |=>
      (flag_c == ($past(opa) >= $past(opb))) && (flag_z == ($past(opa) == $past(opb))));

  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b10) |=> (!res_we && !upd_v && !flag_v && upd_c && upd_z && upd_n));

  a_r9_arith_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b00 || op_sel == 2'b01) |=> (res_we && upd_c && upd_z && upd_v && upd_n));

  a_r10_zn_follow_res: assert property (@(posedge clk) disable iff (!rst_n)
    upd_z |-> ((flag_z == (res == 8'h00)) && (flag_n == res[7])));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b11) |=> (!res_we && !upd_c && !upd_z && !upd_v && !upd_n && res == 8'h00));
endmodule

bind bcd_alu8 bcd_alu8_sva u_sva (.*);

// File: tb/bcd_alu8_tb.sv
`timescale 1ns/1ps
module bcd_alu8_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_sel = 2'b11;
  logic [7:0] opa = 8'h00, opb = 8'h00;
  logic       carry_in = 1'b0, dec_mode = 1'b0;
  logic [7:0] res;
  logic       res_we, flag_c, flag_z, flag_v, flag_n, upd_c, upd_z, upd_v, upd_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_alu8 u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opa(opa), .opb(opb),
    .carry_in(carry_in), .dec_mode(dec_mode), .res(res), .res_we(res_we),
    .flag_c(flag_c), .flag_z(flag_z), .flag_v(flag_v), .flag_n(flag_n),
    .upd_c(upd_c), .upd_z(upd_z), .upd_v(upd_v), .upd_n(upd_n)
  );

  function automatic logic [16:0] pack(int r, bit we, bit c, bit v, bit uv, bit act);
    logic [7:0] rb;
    rb = r[7:0];
    return {rb, we, c, act && (rb == 8'h00), v, act && rb[7], act, act, uv, act};
  endfunction

  function automatic int sgn(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int from_bcd(int b);
    return (b >> 4) * 10 + (b & 15);
  endfunction

  function automatic logic [16:0] model(int op, int a, int m, int c, int d);
    int s, r, sv;
    bit v;
    case (op)
      0: begin
        if (d != 0) begin
          s = from_bcd(a) + from_bcd(m) + c;
          r = to_bcd(s % 100);
          v = (((a ^ r) & (m ^ r)) >> 7) & 1;
          return pack(r, 1, s > 99, v, 1, 1);
        end
        s  = a + m + c;
        sv = sgn(a) + sgn(m) + c;
        return pack(s & 255, 1, s > 255, (sv > 127) || (sv < -128), 1, 1);
      end
      1: begin
        sv = sgn(a) - sgn(m) - (1 - c);
        v  = (sv > 127) || (sv < -128);
        if (d != 0) begin
          s = from_bcd(a) - from_bcd(m) - (1 - c);
          return pack(to_bcd((s + 100) % 100), 1, s >= 0, v, 1, 1);
        end
        s = a - m - (1 - c);
        return pack((s + 512) % 256, 1, s >= 0, v, 1, 1);
      end
      2: return pack((a - m + 256) % 256, 0, a >= m, 0, 0, 1);
      default: return 17'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [16:0] exp);
    logic [16:0] got;
    got = {res, res_we, flag_c, flag_z, flag_v, flag_n, upd_c, upd_z, upd_v, upd_n};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%05h expected=%05h (op=%0d a=%02h m=%02h c=%0d d=%0d)",
               tag, got, exp, op_sel, opa, opb, carry_in, dec_mode);
    end
  endtask

  task automatic apply(string tag, int op, int a, int m, int c, int d);
    @(negedge clk);
    op_sel = op[1:0]; opa = a[7:0]; opb = m[7:0]; carry_in = c[0]; dec_mode = d[0];
    @(posedge clk);
    #1;
    check(tag, model(op, a, m, c, d));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    op_sel = 2'b00; opa = 8'hFF; opb = 8'hFF; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 17'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_add_bin;
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 2)
        for (int c = 0; c < 2; c++)
          apply("R3 R9 R10 add", 0, a, m + ((a >> 3) & 1), c, 0);
  endtask

  task automatic t_sub_bin;
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 2)
        for (int c = 0; c < 2; c++)
          apply("R4 R9 R10 sub", 1, a, m + ((a >> 2) & 1), c, 0);
  endtask

  task automatic t_cmp;
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 4)
        apply("R7 R8 cmp", 2, a, m + (a & 3), (a >> 1) & 1, (a >> 2) & 1);
  endtask

  task automatic t_add_dec;
    for (int i = 0; i < 100; i++)
      for (int j = 0; j < 100; j++)
        apply("R5 decimal add", 0, to_bcd(i), to_bcd(j), (i + j) & 1, 1);
  endtask

  task automatic t_sub_dec;
    for (int i = 0; i < 100; i++)
      for (int j = 0; j < 100; j++)
        apply("R6 decimal sub", 1, to_bcd(i), to_bcd(j), (i ^ j) & 1, 1);
  endtask

  task automatic t_corners;
    apply("R7 cmp 01 vs FF", 2, 8'h01, 8'hFF, 0, 0);
    check("R7 cmp 01 vs FF fixed", {8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1});
    apply("R7 cmp 7F vs 80", 2, 8'h7F, 8'h80, 1, 1);
    check("R7 cmp 7F vs 80 fixed", {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1});
    apply("R5 decimal 99+00+1", 0, 8'h99, 8'h00, 1, 1);
    check("R5 decimal wrap fixed", {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1});
    apply("R6 decimal 00-01", 1, 8'h00, 8'h01, 1, 1);
    check("R6 decimal borrow fixed", {8'h99, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1});
    apply("R3 binary 7F+01", 0, 8'h7F, 8'h01, 0, 0);
    check("R3 overflow fixed", {8'h80, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1});
  endtask

  task automatic t_idle;
    apply("R11 idle", 3, 8'h55, 8'hAA, 1, 1);
    apply("R11 idle zero", 3, 0, 0, 0, 0);
    apply("R2 op after idle", 0, 8'h10, 8'h20, 0, 0);
  endtask

  initial begin
    t_reset();
    t_corners();
    t_idle();
    t_cmp();
    t_add_dec();
    t_sub_dec();
    t_add_bin();
    t_sub_bin();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule